// File: doc/BRIEF.md
# Flash protection level controller

This block holds the protection policy of an embedded flash controller. It keeps two copies of the option values. The pending copy holds a protection key byte and a per-sector write-protect mask. The active copy holds the decoded protection level and the mask that the access checks use. A value written to the pending copy changes nothing until a reload command copies it into the active copy. At reset the block loads the active copy once by itself.

Each flash access request arrives with its kind (read, write or erase), its target (main array or system memory), a page number and a flag that marks debug or alternate-boot origin. The block grants or denies the request in the same cycle. A denied write or erase, or a rejected attempt to reprogram the key at the locked level, sets a sticky error flag. The flag can drive an interrupt. Writing the open key while at level 1 starts a mass erase through a start/done handshake with the array. When the erase completes, the block clears the backup registers and drops to level 0.

Top module: `flash_guard`

## Requirements
- R1: The key byte decodes to a level as follows: 0xAA gives level 0, 0xCC gives level 2, and every other value gives level 1. The `level` output shows the active level with that encoding.
- R2: Writing the key or the mask changes only the pending copy. The active level and active mask take the pending values in the cycle after a `reload` pulse.
- R3: At level 2 every key write is dropped, and `err_flag` is set one cycle later. The level never leaves 2 except through reset.
- R4: At level 2 every request with `acc_dbg`=1 is denied.
- R5: Writing 0xAA at level 1 produces a `merase_start` pulse exactly one cycle long in the next cycle, and `opt_ready` then stays low. In the cycle after `merase_done`, `bkp_clear` pulses for one cycle, `level` reads 0 and `opt_ready` returns high.
- R6: System memory (`acc_sys`=1) grants reads and denies every write and erase, at every level and from every origin.
- R7: In main memory the sector of a page is the page number with its two low bits dropped, and bit n of the active mask protects sector n. Writes and erases to a protected sector are denied, and reads of it are granted.
- R8: Mask writes are accepted at level 2 and take effect after a reload.
- R9: `err_flag` is set by any denied write or erase (kind 1 or 2, or reserved kind 3) and by a rejected key write. It is cleared by `err_clr`=1, and a set in the same cycle wins over the clear. `irq` equals `err_flag` AND `irq_en`.
- R10: After reset `opt_ready` is low and every request is denied, until the active copy has been loaded from the reset option values (default key 0xAA, mask 0).
- R11: At level 1 main memory denies every request with `acc_dbg`=1. At levels 0 and 1 user-origin requests follow R7.
- R12: Access kind encoding is 0 read, 1 write, 2 erase and 3 reserved. Kind 3 is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| key_wr | input | 1 | write pending key byte |
| key_data | input | 8 | key byte value |
| mask_wr | input | 1 | write pending write-protect mask |
| mask_data | input | NSECT | mask value, bit n protects sector n |
| reload | input | 1 | copy pending values to active |
| acc_valid | input | 1 | access request present |
| acc_kind | input | 2 | 0 read, 1 write, 2 erase, 3 reserved |
| acc_sys | input | 1 | 1 targets system memory |
| acc_dbg | input | 1 | 1 for debug or alternate-boot origin |
| acc_page | input | PAGE_W | page number |
| acc_ok | output | 1 | request granted |
| err_clr | input | 1 | clear error flag |
| irq_en | input | 1 | interrupt enable |
| err_flag | output | 1 | sticky protection error |
| irq | output | 1 | interrupt |
| merase_start | output | 1 | mass erase start pulse |
| merase_done | input | 1 | mass erase complete |
| bkp_clear | output | 1 | backup register clear pulse |
| level | output | 2 | active protection level |
| opt_ready | output | 1 | options loaded, no erase in progress |

## Verification
An active copy that is loaded at the wrong time shows up in `level` one cycle after the key write or the reload. It also shows up in the grant of the next access to a protected sector. A fault in the sector decode or the origin gating shows on `acc_ok` in the same cycle as the request, and then on `err_flag` one cycle later. A broken erase sequencer shows as a start pulse longer than one cycle, as `opt_ready` staying high during the erase, or as `level` or `bkp_clear` failing to change in the cycle after `merase_done`.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam logic [7:0] KEY_OPEN = 8'hAA;
  localparam logic [7:0] KEY_LOCK = 8'hCC;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_ER  = 2'd2,
    ACC_RSV = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_ERASE = 2'd2
  } opt_st_e;

  function automatic logic [1:0] key_to_level(input logic [7:0] key);
    if (key == KEY_OPEN)      return 2'd0;
    else if (key == KEY_LOCK) return 2'd2;
    else                      return 2'd1;
  endfunction
endpackage

// File: rtl/fg_opt_ctrl.sv
module fg_opt_ctrl import fg_pkg::*; #(
  parameter int         NSECT    = 8,
  parameter logic [7:0] RST_KEY  = 8'hAA,
  parameter logic [NSECT-1:0] RST_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [7:0]       key_data,
  input  logic             mask_wr,
  input  logic [NSECT-1:0] mask_data,
  input  logic             reload,
  input  logic             merase_done,
  output logic [1:0]       lvl,
  output logic [NSECT-1:0] mask_act,
  output logic             ready,
  output logic             merase_start,
  output logic             bkp_clear,
  output logic             key_reject
);
  opt_st_e          st_q, st_d;
  logic [7:0]       pkey_q, pkey_d;
  logic [NSECT-1:0] pmask_q, pmask_d;
  logic [1:0]       lvl_q, lvl_d;
  logic [NSECT-1:0] amask_q, amask_d;
  logic             start_q, start_d;
  logic             bkp_q, bkp_d;

  always_comb begin
    st_d       = st_q;
    pkey_d     = pkey_q;
    pmask_d    = pmask_q;
    lvl_d      = lvl_q;
    amask_d    = amask_q;
    start_d    = 1'b0;
    bkp_d      = 1'b0;
    key_reject = 1'b0;
    unique case (st_q)
      ST_INIT: begin
        lvl_d   = key_to_level(pkey_q);
        amask_d = pmask_q;
        st_d    = ST_IDLE;
      end
      ST_IDLE: begin
        if (mask_wr) pmask_d = mask_data;
        if (key_wr && lvl_q == 2'd2) begin
          key_reject = 1'b1;
        end else if (key_wr && key_data == KEY_OPEN && lvl_q == 2'd1) begin
          pkey_d  = key_data;
          start_d = 1'b1;
          st_d    = ST_ERASE;
        end else if (key_wr) begin
          pkey_d = key_data;
        end
        if (reload && !start_d) begin
          lvl_d   = key_to_level(pkey_q);
          amask_d = pmask_q;
        end
      end
      ST_ERASE: begin
        if (merase_done) begin
          lvl_d = 2'd0;
          bkp_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_INIT;
      pkey_q  <= RST_KEY;
      pmask_q <= RST_MASK;
      lvl_q   <= 2'd1;
      amask_q <= '1;
      start_q <= 1'b0;
      bkp_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      pkey_q  <= pkey_d;
      pmask_q <= pmask_d;
      lvl_q   <= lvl_d;
      amask_q <= amask_d;
      start_q <= start_d;
      bkp_q   <= bkp_d;
    end
  end

  assign lvl          = lvl_q;
  assign mask_act     = amask_q;
  assign ready        = (st_q == ST_IDLE);
  assign merase_start = start_q;
  assign bkp_clear    = bkp_q;
endmodule

// File: rtl/fg_access_chk.sv
module fg_access_chk import fg_pkg::*; #(
  parameter int PAGE_W = 5,
  localparam int SECT_W = PAGE_W - 2,
  localparam int NSECT  = 1 << SECT_W
) (
  input  logic              ready,
  input  logic [1:0]        lvl,
  input  logic [NSECT-1:0]  mask_act,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic              acc_sys,
  input  logic              acc_dbg,
  input  logic [PAGE_W-1:0] acc_page,
  output logic              acc_ok,
  output logic              deny_mod
);
  logic [SECT_W-1:0] sect;
  logic              sect_prot;
  logic              is_rd, is_mod, path_ok;

  assign sect      = acc_page[PAGE_W-1:2];
  assign sect_prot = mask_act[sect];
  assign is_rd     = (acc_kind == ACC_RD);
  assign is_mod    = (acc_kind == ACC_WR) || (acc_kind == ACC_ER);

  always_comb begin
    if (acc_dbg && lvl == 2'd2)      path_ok = 1'b0;
    else if (acc_sys)                path_ok = is_rd;
    else if (acc_dbg && lvl != 2'd0) path_ok = 1'b0;
    else if (is_rd)                  path_ok = 1'b1;
    else                             path_ok = is_mod && !sect_prot;
  end

  assign acc_ok   = ready && acc_valid && path_ok;
  assign deny_mod = ready && acc_valid && !is_rd && !path_ok;
endmodule

// File: rtl/fg_err_flag.sv
module fg_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_a,
  input  logic set_b,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr)           flag_d = 1'b0;
    if (set_a || set_b) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;
endmodule

// File: rtl/flash_guard.sv
module flash_guard import fg_pkg::*; #(
  parameter int         PAGE_W   = 5,
  parameter logic [7:0] RST_KEY  = 8'hAA,
  localparam int        NSECT    = 1 << (PAGE_W - 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [7:0]        key_data,
  input  logic              mask_wr,
  input  logic [NSECT-1:0]  mask_data,
  input  logic              reload,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic              acc_sys,
  input  logic              acc_dbg,
  input  logic [PAGE_W-1:0] acc_page,
  output logic              acc_ok,
  input  logic              err_clr,
  input  logic              irq_en,
  output logic              err_flag,
  output logic              irq,
  output logic              merase_start,
  input  logic              merase_done,
  output logic              bkp_clear,
  output logic [1:0]        level,
  output logic              opt_ready
);
  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic [NSECT-1:0] mask_act;
  logic             key_reject, deny_mod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  fg_opt_ctrl #(.NSECT(NSECT), .RST_KEY(RST_KEY), .RST_MASK('0)) u_opt (
    .clk(clk), .rst_n(rst_int_n),
    .key_wr(key_wr), .key_data(key_data),
    .mask_wr(mask_wr), .mask_data(mask_data),
    .reload(reload), .merase_done(merase_done),
    .lvl(level), .mask_act(mask_act), .ready(opt_ready),
    .merase_start(merase_start), .bkp_clear(bkp_clear),
    .key_reject(key_reject)
  );

  fg_access_chk #(.PAGE_W(PAGE_W)) u_chk (
    .ready(opt_ready), .lvl(level), .mask_act(mask_act),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_sys(acc_sys),
    .acc_dbg(acc_dbg), .acc_page(acc_page),
    .acc_ok(acc_ok), .deny_mod(deny_mod)
  );

  fg_err_flag u_err (
    .clk(clk), .rst_n(rst_int_n),
    .set_a(deny_mod), .set_b(key_reject), .clr(err_clr),
    .irq_en(irq_en), .flag(err_flag), .irq(irq)
  );
endmodule

// File: rtl/fg_checker.sv
module fg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       key_wr,
  input logic       acc_valid,
  input logic [1:0] acc_kind,
  input logic       acc_sys,
  input logic       acc_dbg,
  input logic       acc_ok,
  input logic       err_flag,
  input logic       merase_start,
  input logic       merase_done,
  input logic       bkp_clear,
  input logic [1:0] level,
  input logic       opt_ready
);
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    level == 2'd2 |=> level == 2'd2);
  a_r3_key_reject_err: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_ready && key_wr && level == 2'd2) |=> err_flag);
  a_r4_dbg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_dbg && level == 2'd2) |-> !acc_ok);
  a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    merase_start |=> !merase_start);
  a_r5_bkp_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    bkp_clear |-> (level == 2'd0 && $past(merase_done)));
  a_r6_sys_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_sys && acc_kind != 2'd0) |-> !acc_ok);
  a_r10_not_ready_deny: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_ready |-> !acc_ok);
endmodule

bind flash_guard fg_checker u_fg_checker (
  .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .acc_valid(acc_valid),
  .acc_kind(acc_kind), .acc_sys(acc_sys), .acc_dbg(acc_dbg), .acc_ok(acc_ok),
  .err_flag(err_flag), .merase_start(merase_start), .merase_done(merase_done),
  .bkp_clear(bkp_clear), .level(level), .opt_ready(opt_ready)
);

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;
  localparam int PAGE_W = 5;
  localparam int NSECT  = 1 << (PAGE_W - 2);

  logic clk, rst_n;
  logic key_wr, mask_wr, reload, acc_valid, acc_sys, acc_dbg;
  logic err_clr, irq_en, merase_done;
  logic [7:0] key_data;
  logic [NSECT-1:0] mask_data;
  logic [1:0] acc_kind;
  logic [PAGE_W-1:0] acc_page;
  logic acc_ok, err_flag, irq, merase_start, bkp_clear, opt_ready;
  logic [1:0] level;

  int total = 0, bad = 0;
  logic [1:0] m_lvl;
  logic [7:0] m_pkey;
  logic [NSECT-1:0] m_pmask, m_amask;
  logic m_err, m_rdy;

  flash_guard #(.PAGE_W(PAGE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data),
    .mask_wr(mask_wr), .mask_data(mask_data), .reload(reload),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_sys(acc_sys),
    .acc_dbg(acc_dbg), .acc_page(acc_page), .acc_ok(acc_ok),
    .err_clr(err_clr), .irq_en(irq_en), .err_flag(err_flag), .irq(irq),
    .merase_start(merase_start), .merase_done(merase_done),
    .bkp_clear(bkp_clear), .level(level), .opt_ready(opt_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] dec(input logic [7:0] k);
    if (k == 8'hAA) return 2'd0;
    if (k == 8'hCC) return 2'd2;
    return 2'd1;
  endfunction

  function automatic logic exp_ok(input logic [1:0] lv, input logic [NSECT-1:0] msk,
      input logic [1:0] kind, input logic sys, input logic dbg, input logic [PAGE_W-1:0] pg);
    if (dbg && lv == 2'd2) return 1'b0;
    if (sys) return kind == 2'd0;
    if (dbg && lv != 2'd0) return 1'b0;
    if (kind == 2'd0) return 1'b1;
    if (kind == 2'd3) return 1'b0;
    return !msk[pg >> 2];
  endfunction

  task automatic idle_in();
    key_wr = 0; mask_wr = 0; reload = 0; acc_valid = 0; err_clr = 0;
    merase_done = 0;
  endtask

  // inputs already set after a negedge; checks grant, then advances one cycle
  task automatic run_cycle(input string tag);
    logic eok, dmod, rej, clr, go_erase;
    logic [7:0] opk; logic [NSECT-1:0] opm;
    #2;
    eok = m_rdy && exp_ok(m_lvl, m_amask, acc_kind, acc_sys, acc_dbg, acc_page);
    if (acc_valid) chk(acc_ok == eok, tag, acc_ok, eok);
    chk(irq == (m_err & irq_en), "R9 irq", irq, m_err & irq_en);
    dmod = m_rdy && acc_valid && acc_kind != 2'd0 && !eok;
    rej  = m_rdy && key_wr && m_lvl == 2'd2;
    clr  = err_clr;
    opk = m_pkey; opm = m_pmask; go_erase = 0;
    if (m_rdy) begin
      if (mask_wr) m_pmask = mask_data;
      if (key_wr && m_lvl != 2'd2) begin
        m_pkey = key_data;
        if (key_data == 8'hAA && m_lvl == 2'd1) go_erase = 1;
      end
      if (reload && !go_erase) begin m_lvl = dec(opk); m_amask = opm; end
      if (go_erase) m_rdy = 0;
    end
    @(negedge clk);
    idle_in();
    if (dmod || rej) m_err = 1; else if (clr) m_err = 0;
    chk(err_flag == m_err, "R9 err_flag", err_flag, m_err);
    chk(level == m_lvl, "R2 level", level, m_lvl);
    chk(opt_ready == m_rdy, "R5 opt_ready", opt_ready, m_rdy);
    if (go_erase) chk(merase_start == 1, "R5 start pulse", merase_start, 1);
  endtask

  task automatic do_erase();
    @(negedge clk);
    chk(merase_start == 0, "R5 start single cycle", merase_start, 0);
    chk(opt_ready == 0, "R5 busy", opt_ready, 0);
    acc_valid = 1; acc_kind = 0; acc_sys = 0; acc_dbg = 0; #2;
    chk(acc_ok == 0, "R10 deny while busy", acc_ok, 0);
    @(negedge clk);
    idle_in(); merase_done = 1;
    @(negedge clk);
    merase_done = 0;
    m_lvl = 0; m_rdy = 1;
    chk(bkp_clear == 1, "R5 bkp_clear", bkp_clear, 1);
    chk(level == 0, "R5 level 0", level, 0);
    chk(opt_ready == 1, "R5 ready again", opt_ready, 1);
    @(negedge clk);
    chk(bkp_clear == 0, "R5 bkp single", bkp_clear, 0);
  endtask

  task automatic access(input logic [1:0] k, input logic s, input logic d,
                        input logic [PAGE_W-1:0] p, input string tag);
    acc_valid = 1; acc_kind = k; acc_sys = s; acc_dbg = d; acc_page = p;
    run_cycle(tag);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    idle_in(); key_data = 0; mask_data = 0; acc_kind = 0; acc_sys = 0;
    acc_dbg = 0; acc_page = 0; irq_en = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk(opt_ready == 0, "R10 not ready at reset", opt_ready, 0);
    acc_valid = 1; #1;
    chk(acc_ok == 0, "R10 deny at reset", acc_ok, 0);
    acc_valid = 0;
    repeat (5) @(negedge clk);
    chk(opt_ready == 1, "R10 ready", opt_ready, 1);
    chk(level == 0, "R10 reset level", level, 0);
    m_lvl = 0; m_pkey = 8'hAA; m_pmask = 0; m_amask = 0; m_err = 0; m_rdy = 1;

    // directed: R2 pending does not act before reload; R7 sector mapping
    mask_wr = 1; mask_data = 8'b0000_0100; run_cycle("R2 mask pend");
    access(2'd1, 0, 0, 5'd9, "R2 write before reload");
    reload = 1; run_cycle("R2 reload");
    access(2'd1, 0, 0, 5'd11, "R7 protected sector write");
    access(2'd0, 0, 0, 5'd8, "R7 protected sector read");
    access(2'd2, 0, 0, 5'd12, "R7 neighbour erase");
    access(2'd3, 0, 0, 5'd0, "R12 reserved kind");
    err_clr = 1; acc_valid = 1; acc_kind = 2'd2; acc_page = 5'd10;
    run_cycle("R9 set wins over clear");
    err_clr = 1; run_cycle("R9 clear");
    access(2'd1, 1, 0, 5'd0, "R6 sys write");
    access(2'd0, 1, 1, 5'd0, "R6 sys read");
    key_wr = 1; key_data = 8'h12; run_cycle("R1 key pend");
    chk(level == 0, "R2 level held", level, 0);
    reload = 1; run_cycle("R1 decode other");
    chk(level == 1, "R1 level 1", level, 1);
    access(2'd0, 0, 1, 5'd1, "R11 dbg read at level 1");
    access(2'd0, 0, 0, 5'd1, "R11 user read at level 1");

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom % 10;
      irq_en = $urandom % 2;
      if (op < 6) begin
        acc_valid = 1; acc_kind = $urandom; acc_sys = ($urandom % 4) == 0;
        acc_dbg = $urandom % 2; acc_page = $urandom;
        run_cycle("R7 random access");
      end else if (op == 6) begin
        mask_wr = 1; mask_data = $urandom; reload = ($urandom % 2);
        run_cycle("R2 random mask");
      end else if (op == 7) begin
        reload = 1; run_cycle("R2 random reload");
      end else if (op == 8) begin
        key_wr = 1;
        key_data = (($urandom % 3) == 0) ? 8'hAA : 8'($urandom);
        if (key_data == 8'hCC) key_data = 8'h5A;
        reload = ($urandom % 2);
        run_cycle("R5 random key");
        if (!m_rdy) do_erase();
      end else begin
        err_clr = 1; run_cycle("R9 random clear");
      end
    end

    // lock to level 2
    key_wr = 1; key_data = 8'hCC; run_cycle("R1 lock pend");
    reload = 1; run_cycle("R1 lock reload");
    chk(level == 2, "R1 level 2", level, 2);
    err_clr = 1; run_cycle("R9 clear");
    access(2'd0, 0, 1, 5'd3, "R4 dbg main read");
    access(2'd0, 1, 1, 5'd3, "R4 dbg sys read");
    err_clr = 1; run_cycle("R9 clear");
    key_wr = 1; key_data = 8'hAA; run_cycle("R3 key rejected");
    chk(err_flag == 1, "R3 err", err_flag, 1);
    reload = 1; run_cycle("R3 reload keeps lock");
    chk(level == 2, "R3 still locked", level, 2);
    chk(merase_start == 0, "R3 no erase", merase_start, 0);
    mask_wr = 1; mask_data = 8'b1000_0000; run_cycle("R8 mask at lock");
    reload = 1; run_cycle("R8 reload");
    access(2'd1, 0, 0, 5'd30, "R8 protected after lock");
    access(2'd1, 0, 0, 5'd2, "R8 open sector");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule